// File: doc/BRIEF.md
# Staged Reset and Configuration-Lock Controller

This block sequences reset for a cell-switching device whose register bank and datapath core come out of reset in two separate, host-controlled stages. It filters an active-low external reset pin so that short glitches do not count as a reset. It holds a small control register with two active-high release bits, one per stage. Writing both bits to zero is a software reset. All timing limits are given in nanoseconds and turned into reference-clock cycle counts, rounding up. The count base is the `REF_CLK_HZ` parameter.

Host accesses arrive on a request channel (`req_valid`/`req_ready`). Every accepted request gets exactly one response one cycle later. Accesses that pass the gate are forwarded to the register bank in that same cycle on the `fwd_*` pins. The gate tracks the reset phase. It refuses extended-space accesses while the bank is still settling. It limits them to the main group while the core is held in reset. Once the core runs, it locks the setup-only registers against writes. Any refused access sets a sticky error flag.

There is no back-pressure from the forward side. `req_ready` is high in every cycle except while a qualified hardware reset is in progress, and a request is accepted in any cycle where `req_valid` and `req_ready` are both high.

Top module: `staged_reset_ctrl`

## Requirements
- R1: A hardware reset takes effect only when `ext_rst_n` has been sampled low on at least HW_MIN consecutive clock edges, where HW_MIN is the larger of 5 and ceil(100 ns × REF_CLK_HZ). In full reset, `phase` = 0 and `bank_rst_n` = `core_rst_n` = 0. A shorter low pulse changes neither the phase nor the reset outputs.
- R2: Writing the control register (address 0x00) with bits [1:0] = 00 is always accepted. From any phase it returns the block to full reset. A following write of 01 is refused until HOLD = ceil(1000 ns × REF_CLK_HZ) cycles after the edge that applied the 00 write.
- R3: In full reset, a write of 01 to bits [1:0] releases the register bank, provided `pll_locked` is high and the hold time of R2 has passed. `bank_rst_n` rises, and `phase` reads 1 (waiting) for BANK_SETTLE = ceil(1000 ns × REF_CLK_HZ) cycles and then 2 (bank only).
- R4: While `pll_locked` is low, a write of 01 to the release bits is refused.
- R5: Addresses 0x10 and above form the extended space. Extended accesses are refused in phases 0 and 1. In phase 2 only the main group 0x10–0x2F is accepted. In phase 3 every extended access is accepted except the writes covered by R6. Addresses 0x01–0x0F are always accepted and forwarded.
- R6: Setup-only registers at 0x20–0x2F accept writes only in phase 2. In phase 3 such writes are refused and not forwarded, while reads are still forwarded.
- R7: In phase 2, a write of 11 to the release bits releases the core. `core_rst_n` rises and stays high. `phase` reads 1 for 3 × SLOW_DIV cycles and then 3 (running). A write of 11 in any other phase, other than a repeat of the current value, is refused. A write of 01 outside full reset is also refused, unless it repeats the current value. `core_rst_n` is never high while `bank_rst_n` is low.
- R8: Each accepted request produces `rsp_valid` on the next cycle, with `rsp_reject` giving the outcome. A granted access to a nonzero address appears on `fwd_*` in the same cycle as its response. A read of 0x00 returns the release bits in [1:0], the error flag in [2] and the phase in [5:4], with all other bits zero. Every other response carries zero data.
- R9: `access_err` is set by any refused request. A write to 0x00 with bit 2 = 1 clears it. If that same write is refused, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pll_locked | input | 1 | Clock PLL reports stable |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be taken (low during hardware reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_reject | output | 1 | Request was refused |
| rsp_rdata | output | DATA_W | Control register readback, else zero |
| fwd_valid | output | 1 | Granted access toward the register bank |
| fwd_write | output | 1 | Forwarded direction |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| bank_rst_n | output | 1 | Register bank reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| phase | output | 2 | 0 full reset, 1 waiting, 2 bank only, 3 running |
| access_err | output | 1 | Sticky refused-access flag |

## Verification
The properties assume that the host presents at most one request per cycle and never drives `req_valid` while `req_ready` is low. They also assume `pll_locked` is steady around each release write, and that `ext_rst_n` is first held low long enough to qualify, so that every register has a defined value before checking starts. The stimulus changes all inputs only on falling clock edges. It issues one request at a time through a single driver task and applies a long pin pulse at start-up before any request is sent. The release writes are timed to land exactly one cycle before and exactly at each hold and settle boundary.

// File: rtl/srcl_pkg.sv
package srcl_pkg;

  typedef enum logic [2:0] {
    ST_FULL,
    ST_BSET,
    ST_BANK,
    ST_CSET,
    ST_RUN
  } state_e;

  localparam logic [1:0] PH_FULL = 2'd0;
  localparam logic [1:0] PH_WAIT = 2'd1;
  localparam logic [1:0] PH_BANK = 2'd2;
  localparam logic [1:0] PH_RUN  = 2'd3;

  // address map boundaries (extended space starts at EXT_LO)
  localparam int EXT_LO   = 16;
  localparam int SETUP_LO = 32;
  localparam int SETUP_HI = 48;

  function automatic logic [1:0] phase_of(state_e s);
    case (s)
      ST_FULL: return PH_FULL;
      ST_BANK: return PH_BANK;
      ST_RUN:  return PH_RUN;
      default: return PH_WAIT;
    endcase
  endfunction

  function automatic int ceil_cycles(longint hz, longint ns);
    return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srcl_pin_filter.sv
module srcl_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 5
) (
  input  logic clk,
  input  logic pin_n,
  output logic rst_req
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_LOW - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       low_cnt;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  always_ff @(posedge clk) begin
    if (sync_q[SYNC_STAGES-1]) begin
      low_cnt <= '0;
    end else if (low_cnt != LIM) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rst_req = !sync_q[SYNC_STAGES-1] && (low_cnt == LIM);
endmodule

// File: rtl/srcl_timer.sv
module srcl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/srcl_access_gate.sv
module srcl_access_gate
  import srcl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  state_e            state,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_ctrl,
  output logic              allow
);
  localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(EXT_LO);
  localparam logic [ADDR_W-1:0] A_SETLO = ADDR_W'(SETUP_LO);
  localparam logic [ADDR_W-1:0] A_SETHI = ADDR_W'(SETUP_HI);

  logic in_main, in_setup;

  always_comb begin
    in_main  = (addr >= A_EXT) && (addr < A_SETHI);
    in_setup = (addr >= A_SETLO) && (addr < A_SETHI);
    is_ctrl  = (addr == '0);
    allow    = 1'b0;
    if (addr < A_EXT) begin
      allow = 1'b1;
    end else begin
      case (state)
        ST_BANK: allow = in_main;
        ST_RUN:  allow = !(in_setup && write);
        default: allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/staged_reset_ctrl.sv
module staged_reset_ctrl
  import srcl_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ = 50_000_000,
  parameter int          SLOW_DIV   = 4,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 16
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              pll_locked,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_reject,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              bank_rst_n,
  output logic              core_rst_n,
  output logic [1:0]        phase,
  output logic              access_err
);
  localparam int HW_MIN     = max_int(5, ceil_cycles(longint'(REF_CLK_HZ), 100));
  localparam int HOLD_CYC   = ceil_cycles(longint'(REF_CLK_HZ), 1000);
  localparam int BANK_CYC   = ceil_cycles(longint'(REF_CLK_HZ), 1000);
  localparam int CORE_CYC   = 3 * SLOW_DIV;
  localparam int TMR_MAX    = max_int(max_int(HOLD_CYC, BANK_CYC), CORE_CYC);
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  state_e             state_q, state_d;
  logic               rst_req;
  logic               tmr_load, tmr_done;
  logic [TMR_W-1:0]   tmr_val;
  logic               is_ctrl, gate_ok;
  logic               accept, ctrl_wr, legal, reject;
  logic [1:0]         cur_bits, new_bits;
  logic               err_q;
  logic [DATA_W-1:0]  rd_d;

  srcl_pin_filter #(.SYNC_STAGES(2), .MIN_LOW(HW_MIN)) u_filter (
    .clk     (clk),
    .pin_n   (ext_rst_n),
    .rst_req (rst_req)
  );

  srcl_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  srcl_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .state   (state_q),
    .write   (req_write),
    .addr    (req_addr),
    .is_ctrl (is_ctrl),
    .allow   (gate_ok)
  );

  assign req_ready = !rst_req;
  assign accept    = req_valid && req_ready;
  assign cur_bits  = {(state_q == ST_CSET) || (state_q == ST_RUN), state_q != ST_FULL};
  assign new_bits  = req_wdata[1:0];
  assign ctrl_wr   = accept && is_ctrl && req_write;

  always_comb begin
    legal = (new_bits == 2'b00) || (new_bits == cur_bits)
         || ((new_bits == 2'b01) && (state_q == ST_FULL) && pll_locked && tmr_done)
         || ((new_bits == 2'b11) && (state_q == ST_BANK) && pll_locked);
    reject = accept && (is_ctrl ? (req_write && !legal) : !gate_ok);
  end

  // phase sequencing; control writes override settle completion
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_BSET && tmr_done) state_d = ST_BANK;
    if (state_q == ST_CSET && tmr_done) state_d = ST_RUN;
    if (ctrl_wr && legal) begin
      if (new_bits == 2'b00) begin
        state_d  = ST_FULL;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYC - 1);
      end else if (new_bits == 2'b01 && state_q == ST_FULL) begin
        state_d  = ST_BSET;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(BANK_CYC - 1);
      end else if (new_bits == 2'b11 && state_q == ST_BANK) begin
        state_d  = ST_CSET;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CORE_CYC - 1);
      end
    end
    if (rst_req) begin
      state_d  = ST_FULL;
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(HOLD_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst_req) begin
      err_q <= 1'b0;
    end else if (reject) begin
      err_q <= 1'b1;
    end else if (ctrl_wr && req_wdata[2]) begin
      err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    if (accept && is_ctrl && !req_write) begin
      rd_d[1:0] = cur_bits;
      rd_d[2]   = err_q;
      rd_d[5:4] = phase_of(state_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_req) begin
      rsp_valid  <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_rdata  <= '0;
      fwd_valid  <= 1'b0;
    end else begin
      rsp_valid  <= accept;
      rsp_reject <= reject;
      rsp_rdata  <= rd_d;
      fwd_valid  <= accept && !is_ctrl && !reject;
    end
    fwd_write <= req_write;
    fwd_addr  <= req_addr;
    fwd_wdata <= req_wdata;
  end

  assign bank_rst_n = (state_q != ST_FULL);
  assign core_rst_n = (state_q == ST_CSET) || (state_q == ST_RUN);
  assign phase      = phase_of(state_q);
  assign access_err = err_q;
endmodule

// File: rtl/staged_reset_ctrl_chk.sv
module staged_reset_ctrl_chk
  import srcl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_req,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_reject,
  input logic              access_err,
  input logic              fwd_valid,
  input logic              fwd_write,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [1:0]        phase,
  input logic              bank_rst_n,
  input logic              core_rst_n
);
  localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(EXT_LO);
  localparam logic [ADDR_W-1:0] A_SETLO = ADDR_W'(SETUP_LO);
  localparam logic [ADDR_W-1:0] A_SETHI = ADDR_W'(SETUP_HI);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst_req) armed <= 1'b1;
  end

  AST_CORE_AFTER_BANK: assert property (@(posedge clk) disable iff (rst_req || !armed)
    core_rst_n |-> bank_rst_n); // R7
  AST_RUN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst_req || !armed)
    (phase == PH_RUN && $past(phase) != PH_RUN) |-> $past(core_rst_n)); // R7
  AST_BANK_WAITS_FIRST: assert property (@(posedge clk) disable iff (rst_req || !armed)
    $rose(bank_rst_n) |-> phase == PH_WAIT); // R3
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst_req || !armed)
    (fwd_valid && fwd_addr >= A_EXT) |-> ($past(phase) == PH_BANK || $past(phase) == PH_RUN)); // R5
  AST_SETUP_LOCKED: assert property (@(posedge clk) disable iff (rst_req || !armed)
    (fwd_valid && fwd_write && fwd_addr >= A_SETLO && fwd_addr < A_SETHI) |-> $past(phase) == PH_BANK); // R6
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst_req || !armed)
    rsp_valid |-> $past(req_valid)); // R8
  AST_FWD_ONLY_GRANTED: assert property (@(posedge clk) disable iff (rst_req || !armed)
    fwd_valid |-> (rsp_valid && !rsp_reject)); // R8
  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (rst_req || !armed)
    (rsp_valid && rsp_reject) |-> access_err); // R9
endmodule

bind staged_reset_ctrl staged_reset_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_req    (rst_req),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_reject (rsp_reject),
  .access_err (access_err),
  .fwd_valid  (fwd_valid),
  .fwd_write  (fwd_write),
  .fwd_addr   (fwd_addr),
  .phase      (phase),
  .bank_rst_n (bank_rst_n),
  .core_rst_n (core_rst_n)
);

// File: tb/staged_reset_ctrl_tb_top.sv
module staged_reset_ctrl_tb_top;
  // timing at 50 MHz: 100 ns -> 5, 1 us -> 50, 3 slow periods of 4 -> 12
  localparam int HW_MIN   = 5;
  localparam int HOLD_CYC = 50;
  localparam int BANK_CYC = 50;
  localparam int CORE_CYC = 12;

  logic        clk = 1'b0;
  logic        ext_rst_n, pll_locked;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid, rsp_reject;
  logic [15:0] rsp_rdata;
  logic        fwd_valid, fwd_write;
  logic [7:0]  fwd_addr;
  logic [15:0] fwd_wdata;
  logic        bank_rst_n, core_rst_n, access_err;
  logic [1:0]  phase;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        rej;
    logic        fwd;
    logic [7:0]  addr;
    logic [15:0] rdata;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  staged_reset_ctrl dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .pll_locked(pll_locked),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_reject(rsp_reject), .rsp_rdata(rsp_rdata),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .bank_rst_n(bank_rst_n), .core_rst_n(core_rst_n),
    .phase(phase), .access_err(access_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected response, then presents the request for one edge
  task automatic access(input logic we, input logic [7:0] a, input logic [15:0] d,
                        input logic rej, input logic [15:0] rd, input string tag);
    exp_t e;
    e.rej = rej; e.fwd = !rej && (a != 8'h00); e.addr = a; e.rdata = rd; e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pin_pulse(input int n);
    ext_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected response", 16'h1, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " reject"}, {15'h0, rsp_reject}, {15'h0, e.rej});
        chk({e.tag, " rdata"}, rsp_rdata, e.rdata);
        chk({e.tag, " forwarded"}, {15'h0, fwd_valid}, {15'h0, e.fwd});
        if (e.fwd) chk({e.tag, " fwd addr"}, {8'h0, fwd_addr}, {8'h0, e.addr});
      end
    end else if (fwd_valid) begin
      chk("R8 forward without response", 16'h1, 16'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    ext_rst_n = 1'b0; pll_locked = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (10) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 phase after pin reset", {14'h0, phase}, 16'd0);
    chk("R1 bank reset", {15'h0, bank_rst_n}, 16'd0);
    chk("R1 core reset", {15'h0, core_rst_n}, 16'd0);
    chk("R9 error clear at reset", {15'h0, access_err}, 16'd0);
    repeat (60) @(negedge clk);

    access(1'b1, 8'h00, 16'h0001, 1'b1, 16'h0, "R4 release without pll");
    chk("R9 error set", {15'h0, access_err}, 16'd1);
    access(1'b0, 8'h10, 16'h0, 1'b1, 16'h0, "R5 extended in full reset");
    access(1'b0, 8'h00, 16'h0, 1'b0, 16'h0004, "R8 control read full");
    access(1'b1, 8'h00, 16'h0004, 1'b0, 16'h0, "R9 clear with soft reset");
    chk("R9 error cleared", {15'h0, access_err}, 16'd0);
    access(1'b0, 8'h05, 16'h0, 1'b0, 16'h0, "R5 direct space always open");

    pll_locked = 1'b1;
    repeat (60) @(negedge clk);
    access(1'b1, 8'h00, 16'h0001, 1'b0, 16'h0, "R3 bank release");
    chk("R3 bank out of reset", {15'h0, bank_rst_n}, 16'd1);
    chk("R3 phase waiting", {14'h0, phase}, 16'd1);
    access(1'b0, 8'h10, 16'h0, 1'b1, 16'h0, "R5 extended while bank settles");
    repeat (BANK_CYC - 2) @(negedge clk);
    chk("R3 still waiting at last settle cycle", {14'h0, phase}, 16'd1);
    @(negedge clk);
    chk("R3 bank-only after settle", {14'h0, phase}, 16'd2);
    chk("R7 core held", {15'h0, core_rst_n}, 16'd0);

    access(1'b1, 8'h20, 16'hBEEF, 1'b0, 16'h0, "R6 setup write in bank-only");
    access(1'b1, 8'h30, 16'h0001, 1'b1, 16'h0, "R5 non-main write in bank-only");
    access(1'b0, 8'h1F, 16'h0, 1'b0, 16'h0, "R5 main read in bank-only");
    access(1'b0, 8'h00, 16'h0, 1'b0, 16'h0025, "R8 control read bank-only");
    access(1'b1, 8'h00, 16'h0005, 1'b0, 16'h0, "R9 clear keeping bits");
    chk("R9 error cleared", {15'h0, access_err}, 16'd0);
    chk("R9 phase kept", {14'h0, phase}, 16'd2);
    access(1'b1, 8'h00, 16'h0006, 1'b1, 16'h0, "R9 refused clear sets flag");
    chk("R9 set wins", {15'h0, access_err}, 16'd1);

    access(1'b1, 8'h00, 16'h0003, 1'b0, 16'h0, "R7 core release");
    chk("R7 core out of reset", {15'h0, core_rst_n}, 16'd1);
    chk("R7 phase waiting", {14'h0, phase}, 16'd1);
    access(1'b1, 8'h10, 16'h0, 1'b1, 16'h0, "R5 extended while core settles");
    repeat (CORE_CYC - 2) @(negedge clk);
    chk("R7 still waiting", {14'h0, phase}, 16'd1);
    @(negedge clk);
    chk("R7 running", {14'h0, phase}, 16'd3);

    access(1'b1, 8'h20, 16'h1234, 1'b1, 16'h0, "R6 setup write locked");
    access(1'b0, 8'h2F, 16'h0, 1'b0, 16'h0, "R6 setup read in run");
    access(1'b1, 8'h35, 16'h0005, 1'b0, 16'h0, "R5 other extended in run");
    access(1'b1, 8'h00, 16'h0001, 1'b1, 16'h0, "R7 bank-only value from run");
    access(1'b1, 8'h00, 16'h0003, 1'b0, 16'h0, "R7 repeat of current bits");
    chk("R7 still running", {14'h0, phase}, 16'd3);

    pin_pulse(HW_MIN - 1);
    repeat (6) @(negedge clk);
    chk("R1 short pulse ignored phase", {14'h0, phase}, 16'd3);
    chk("R1 short pulse ignored core", {15'h0, core_rst_n}, 16'd1);

    access(1'b1, 8'h00, 16'h0000, 1'b0, 16'h0, "R2 soft reset");
    chk("R2 phase full", {14'h0, phase}, 16'd0);
    chk("R2 bank reset", {15'h0, bank_rst_n}, 16'd0);
    chk("R2 core reset", {15'h0, core_rst_n}, 16'd0);
    access(1'b1, 8'h00, 16'h0001, 1'b1, 16'h0, "R2 release right after soft reset");
    repeat (HOLD_CYC - 3) @(negedge clk);
    access(1'b1, 8'h00, 16'h0001, 1'b1, 16'h0, "R2 release one cycle early");
    access(1'b1, 8'h00, 16'h0001, 1'b0, 16'h0, "R2 release at hold limit");
    chk("R2 bank released", {15'h0, bank_rst_n}, 16'd1);

    pin_pulse(HW_MIN);
    repeat (4) @(negedge clk);
    chk("R1 minimum pulse phase", {14'h0, phase}, 16'd0);
    chk("R1 minimum pulse bank", {15'h0, bank_rst_n}, 16'd0);

    repeat (3) @(negedge clk);
    chk("R8 all responses seen", 16'(exp_q.size()), 16'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule